// File: doc/BRIEF.md
# Configuration-link target register block

This block is the device-side register set that a host drives while it loads a configuration image into the fabric over the link. The host reaches it with 32-bit register reads and writes at fixed offsets. It keeps a mode register, which holds the configuration-mode bit, a clock-source select and a clocks-per-word value. It also keeps a program-control register, which holds a configuration request and a start-transfer flag.

The status the host polls is not a stored copy of what it wrote. Config-ready comes up a fixed number of cycles after a request made in configuration mode. Data words written while ready and transferring are counted, and config-done is raised when the count reaches the image length. Ready drops only after the request is withdrawn and a run of flush writes has arrived. When the host then leaves configuration mode with the clock select cleared, the fabric is reported as running in user mode.

Errors come from a sideband input or from a mode bit set before the clock select. An error is flagged in status and also kept in a sticky error register until reset. Decoding the bitstream and the link layer belong elsewhere.

Top module: `cfglink_target_regs`

## Requirements
- R1: After reset, offset 0x200 reads 0x0000000B and the status register at 0x21C reads 0x00100000. Status bits: 18 ready, 19 error, 20 enable (always 1), 21 user mode, 23 done, 24 fabric clock in use. All other status bits read 0.
- R2: The mode register at 0x220 stores bit 0 (configuration mode), bit 1 (clock select) and bits 15:8 (clocks per word), and reads back those fields with all other bits 0. Output clk_sel_pma follows the stored bit 1.
- R3: The program-control register at 0x22C stores bit 0 (request) and bit 1 (start transfer) and reads them back.
- R4: Status bit 18 becomes 1 on the (READY_DELAY+1)-th clock edge after the edge that stores the request, but only while the mode bit is 1. With the mode bit 0, a held request never raises it.
- R5: Status bit 18 stays 1 after the request is cleared and falls only on the FLUSH_WORDS-th write to the data offset 0x228 after that.
- R6: A write to 0x228 is counted only while ready and start transfer are both 1. Status bit 23 becomes 1 on the IMAGE_WORDS-th counted write and is cleared by the next request that starts a load.
- R7: Input err_inject sets status bit 19 and bit 5 of 0x234. Bit 19 is cleared when a new load starts. Bit 5 of 0x234 stays set until reset.
- R8: A write that sets the mode bit while both the stored mode bit and the stored clock select are 0 is a sequencing error, with the same effect as R7.
- R9: Once done is 1, with no latched error and no load in progress, clearing both the mode bit and the clock select makes user_mode and status bits 21 and 24 equal to 1 one edge later. These three are 0 at any other time.
- R10: Reads of unmapped offsets and of 0x228 return 0. Writes to 0x200, 0x21C and 0x234 change nothing.
- R11: A read with rd_en presents its data on rdata with rd_valid one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rd_valid | output | 1 | rdata holds the result of the previous cycle's read |
| err_inject | input | 1 | Sideband configuration-error request |
| clk_sel_pma | output | 1 | Selected clock source (stored clock-select bit) |
| user_mode | output | 1 | Fabric reported as running the loaded image |

## Verification
A phase engine in the wrong state shows up in the ready bit of the next status read. A ready bit that rises too early, never falls, or falls before the last flush write is visible within the few cycles the checks allow around each edge. A miscounted word shows up as the done bit flipping one write early or late. A lost or early-cleared error latch shows at the 0x234 read that follows the next load start, and also as user_mode rising when it should stay low.

// File: rtl/cfglink_pkg.sv
package cfglink_pkg;

   localparam logic [11:0] OFS_CAPID  = 12'h200;
   localparam logic [11:0] OFS_STATUS = 12'h21C;
   localparam logic [11:0] OFS_MODE   = 12'h220;
   localparam logic [11:0] OFS_DATA   = 12'h228;
   localparam logic [11:0] OFS_PROG   = 12'h22C;
   localparam logic [11:0] OFS_ERRLAT = 12'h234;

   localparam logic [15:0] CAP_ID_VAL = 16'h000B;

   localparam int ST_READY  = 18;
   localparam int ST_ERR    = 19;
   localparam int ST_EN     = 20;
   localparam int ST_USER   = 21;
   localparam int ST_DONE   = 23;
   localparam int ST_FABCLK = 24;

   localparam int MD_MODE    = 0;
   localparam int MD_CLKSEL  = 1;
   localparam int MD_NCLK_LO = 8;
   localparam int PG_REQ     = 0;
   localparam int PG_XFER    = 1;
   localparam int EL_CFGERR  = 5;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WAIT  = 2'd1,
      PH_READY = 2'd2,
      PH_FLUSH = 2'd3
   } phase_t;

   typedef struct packed {
      logic       mode;
      logic       clksel;
      logic [7:0] nclk;
      logic       req;
      logic       xfer;
   } ctrl_t;

endpackage

// File: rtl/cfglink_ctrl.sv
module cfglink_ctrl
   import cfglink_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl,
   output logic              seq_err
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_PROG = ADDR_W'(OFS_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         seq_err <= 1'b0;
      end else begin
         seq_err <= 1'b0;
         if (wr_en && addr == A_MODE) begin
            ctrl.mode   <= wdata[MD_MODE];
            ctrl.clksel <= wdata[MD_CLKSEL];
            ctrl.nclk   <= wdata[MD_NCLK_LO +: 8];
            // clock source has to be chosen before the mode bit goes up
            seq_err     <= wdata[MD_MODE] & ~ctrl.mode & ~ctrl.clksel;
         end
         if (wr_en && addr == A_PROG) begin
            ctrl.req  <= wdata[PG_REQ];
            ctrl.xfer <= wdata[PG_XFER];
         end
      end
   end

endmodule

// File: rtl/cfglink_seq.sv
module cfglink_seq
   import cfglink_pkg::*;
#(
   parameter int READY_DELAY = 4,
   parameter int FLUSH_WORDS = 4,
   parameter int IMAGE_WORDS = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  logic  data_wr,
   input  logic  err_evt,
   output logic  cfg_ready,
   output logic  cfg_done,
   output logic  err_live,
   output logic  err_latch,
   output logic  user_act
);

   localparam int WAIT_W = (READY_DELAY > 1) ? $clog2(READY_DELAY) : 1;
   localparam int WORD_W = $clog2(IMAGE_WORDS + 1);
   localparam int FL_W   = $clog2(FLUSH_WORDS + 1);

   phase_t            phase_q;
   logic [WORD_W-1:0] words_q;
   logic [FL_W-1:0]   fcnt_q;
   logic              done_q, err_live_q, err_latch_q, user_q;
   logic              wait_hit;

   generate
      if (READY_DELAY > 1) begin : g_wait_cnt
         logic [WAIT_W-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 wcnt_q <= '0;
            else if (phase_q != PH_WAIT) wcnt_q <= '0;
            else                        wcnt_q <= wcnt_q + 1'b1;
         end
         assign wait_hit = (wcnt_q == WAIT_W'(READY_DELAY - 1));
      end else begin : g_wait_one
         assign wait_hit = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         words_q     <= '0;
         fcnt_q      <= '0;
         done_q      <= 1'b0;
         err_live_q  <= 1'b0;
         err_latch_q <= 1'b0;
         user_q      <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (ctrl.req && ctrl.mode) begin
               phase_q    <= PH_WAIT;
               done_q     <= 1'b0;
               words_q    <= '0;
               err_live_q <= 1'b0;
            end
            PH_WAIT: begin
               if (!ctrl.req)    phase_q <= PH_IDLE;
               else if (wait_hit) phase_q <= PH_READY;
            end
            PH_READY: begin
               if (!ctrl.req) begin
                  phase_q <= PH_FLUSH;
                  fcnt_q  <= '0;
               end else if (data_wr && ctrl.xfer && !done_q) begin
                  words_q <= words_q + 1'b1;
                  if (words_q == WORD_W'(IMAGE_WORDS - 1)) done_q <= 1'b1;
               end
            end
            default: if (data_wr) begin
               if (fcnt_q == FL_W'(FLUSH_WORDS - 1)) phase_q <= PH_IDLE;
               else                                  fcnt_q  <= fcnt_q + 1'b1;
            end
         endcase
         if (err_evt) begin
            err_live_q  <= 1'b1;
            err_latch_q <= 1'b1;
         end
         user_q <= (phase_q == PH_IDLE) && done_q && !err_latch_q && !err_evt
                   && !ctrl.mode && !ctrl.clksel;
      end
   end

   assign cfg_ready = (phase_q == PH_READY) || (phase_q == PH_FLUSH);
   assign cfg_done  = done_q;
   assign err_live  = err_live_q;
   assign err_latch = err_latch_q;
   assign user_act  = user_q;

   AST_READY_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_ready) |-> $past(ctrl.req)); // R4
   AST_READY_FALL_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_ready) |-> $past(data_wr)); // R5
   AST_DONE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_done) |-> $past(data_wr && ctrl.xfer)); // R6
   AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_latch |=> err_latch); // R7
   AST_USER_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      user_act |-> (cfg_done && !err_latch && !ctrl.mode)); // R9

endmodule

// File: rtl/cfglink_rdmux.sv
module cfglink_rdmux
   import cfglink_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  ctrl_t             ctrl,
   input  logic              cfg_ready,
   input  logic              cfg_done,
   input  logic              err_live,
   input  logic              err_latch,
   input  logic              user_act,
   output logic [DATA_W-1:0] rd_word
);

   always_comb begin
      rd_word = '0;
      case (addr)
         ADDR_W'(OFS_CAPID):  rd_word[15:0] = CAP_ID_VAL;
         ADDR_W'(OFS_STATUS): begin
            rd_word[ST_READY]  = cfg_ready;
            rd_word[ST_ERR]    = err_live;
            rd_word[ST_EN]     = 1'b1;
            rd_word[ST_USER]   = user_act;
            rd_word[ST_DONE]   = cfg_done;
            rd_word[ST_FABCLK] = user_act;
         end
         ADDR_W'(OFS_MODE): begin
            rd_word[MD_MODE]         = ctrl.mode;
            rd_word[MD_CLKSEL]       = ctrl.clksel;
            rd_word[MD_NCLK_LO +: 8] = ctrl.nclk;
         end
         ADDR_W'(OFS_PROG): begin
            rd_word[PG_REQ]  = ctrl.req;
            rd_word[PG_XFER] = ctrl.xfer;
         end
         ADDR_W'(OFS_ERRLAT): rd_word[EL_CFGERR] = err_latch;
         default: rd_word = '0;
      endcase
   end

endmodule

// File: rtl/cfglink_target_regs.sv
module cfglink_target_regs
   import cfglink_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int READY_DELAY = 4,
   parameter int FLUSH_WORDS = 4,
   parameter int IMAGE_WORDS = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   input  logic              err_inject,
   output logic              clk_sel_pma,
   output logic              user_mode
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("cfglink_target_regs: DATA_W must be 32");
      end
      if (ADDR_W < 10 || ADDR_W > 12) begin : g_bad_addr
         $error("cfglink_target_regs: ADDR_W must be 10..12");
      end
      if (READY_DELAY < 1) begin : g_bad_delay
         $error("cfglink_target_regs: READY_DELAY must be at least 1");
      end
      if (FLUSH_WORDS < 1 || IMAGE_WORDS < 1) begin : g_bad_counts
         $error("cfglink_target_regs: FLUSH_WORDS and IMAGE_WORDS must be positive");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              seq_err, err_sync, err_evt, data_wr;
   logic              cfg_ready, cfg_done, err_live, err_latch, user_act;
   logic [DATA_W-1:0] rd_word;

   generate
      if (SYNC_STAGES > 0) begin : g_err_sync
         logic [SYNC_STAGES:0] chain;
         assign chain[0] = err_inject;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i+1] <= 1'b0;
               else        chain[i+1] <= chain[i];
            end
         end
         assign err_sync = chain[SYNC_STAGES];
      end else begin : g_err_direct
         assign err_sync = err_inject;
      end
   endgenerate

   assign data_wr = wr_en && (addr == ADDR_W'(OFS_DATA));
   assign err_evt = err_sync | seq_err;

   cfglink_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ctrl(ctrl), .seq_err(seq_err)
   );

   cfglink_seq #(
      .READY_DELAY(READY_DELAY), .FLUSH_WORDS(FLUSH_WORDS), .IMAGE_WORDS(IMAGE_WORDS)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .data_wr(data_wr), .err_evt(err_evt),
      .cfg_ready(cfg_ready), .cfg_done(cfg_done), .err_live(err_live),
      .err_latch(err_latch), .user_act(user_act)
   );

   cfglink_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rdmux_i (
      .addr(addr), .ctrl(ctrl), .cfg_ready(cfg_ready), .cfg_done(cfg_done),
      .err_live(err_live), .err_latch(err_latch), .user_act(user_act),
      .rd_word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_word;
      end
   end

   assign clk_sel_pma = ctrl.clksel;
   assign user_mode   = user_act;

   AST_CLKSEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl.mode) && !$past(ctrl.clksel)) |=> err_latch); // R8
   AST_RD_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R11
   AST_USER_PORT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> $past(!ctrl.mode && !ctrl.clksel)); // R9

endmodule

// File: tb/cfglink_target_regs_tb_top.sv
module cfglink_target_regs_tb_top;

   localparam int D  = 4;
   localparam int FW = 4;
   localparam int IW = 6;

   localparam logic [11:0] A_CAP = 12'h200, A_ST = 12'h21C, A_MD = 12'h220,
                           A_DAT = 12'h228, A_PG = 12'h22C, A_EL = 12'h234;
   localparam logic [31:0] B_RDY = 32'h1 << 18, B_ERR = 32'h1 << 19, B_EN = 32'h1 << 20,
                           B_USR = 32'h1 << 21, B_DN = 32'h1 << 23, B_FAB = 32'h1 << 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, err_inject = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rd_valid, clk_sel_pma, user_mode;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [31:0] exp;
      logic [31:0] mask;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   cfglink_target_regs #(
      .ADDR_W(12), .DATA_W(32), .READY_DELAY(D), .FLUSH_WORDS(FW),
      .IMAGE_WORDS(IW), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err_inject(err_inject),
      .clk_sel_pma(clk_sel_pma), .user_mode(user_mode)
   );

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rd_valid) begin
         n_cmp++;
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected read data act=%h exp=none", rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if ((rdata & e.mask) !== (e.exp & e.mask)) begin
               n_bad++;
               $display("FAIL %s act=%h exp=%h", e.tag, rdata & e.mask, e.exp & e.mask);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input logic [31:0] m,
                     input string tag);
      sb_q.push_back('{exp: e, mask: m, tag: tag});
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input logic act, input logic e, input string tag);
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s act=%b exp=%b", tag, act, e);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1 reset state
      rd(A_CAP, 32'h0000_000B, '1, "R1 capability id");
      rd(A_ST, B_EN, '1, "R1 status after reset");
      rd(A_MD, 32'h0, '1, "R2 mode after reset");
      rd(A_PG, 32'h0, '1, "R3 prog after reset");
      rd(A_EL, 32'h0, '1, "R7 latch after reset");
      chk(clk_sel_pma, 1'b0, "R2 clk_sel_pma after reset");
      chk(user_mode, 1'b0, "R9 user_mode after reset");

      // R2 clock select first, clocks-per-word 5
      wr(A_MD, 32'hFFFF_0502);
      rd(A_MD, 32'h0000_0502, '1, "R2 mode readback");
      chk(clk_sel_pma, 1'b1, "R2 clk_sel_pma set");

      // R4 request without mode never raises ready
      wr(A_PG, 32'h1);
      repeat (D + 3) @(negedge clk);
      rd(A_ST, B_EN, '1, "R4 no ready without mode");
      rd(A_PG, 32'h1, '1, "R3 prog request readback");
      wr(A_PG, 32'h0);

      wr(A_MD, 32'h0000_0503);
      rd(A_EL, 32'h0, '1, "R8 legal order gives no error");

      // R4 ready timing
      wr(A_PG, 32'h1);
      repeat (D) @(negedge clk);
      rd(A_ST, 32'h0, B_RDY, "R4 ready not yet");
      rd(A_ST, B_EN | B_RDY, '1, "R4 ready raised");

      // R6 counting
      wr(A_PG, 32'h3);
      rd(A_PG, 32'h3, '1, "R3 prog start readback");
      for (int i = 0; i < IW - 1; i++) wr(A_DAT, 32'hA5A5_0000 + 32'(i));
      rd(A_ST, B_EN | B_RDY, '1, "R6 done not before last word");
      wr(A_DAT, 32'h1234_5678);
      rd(A_ST, B_EN | B_RDY | B_DN, '1, "R6 done on last word");
      wr(A_DAT, 32'h0);

      // R5 flush
      wr(A_PG, 32'h0);
      rd(A_ST, B_EN | B_RDY | B_DN, '1, "R5 ready held after request cleared");
      for (int i = 0; i < FW - 1; i++) wr(A_DAT, 32'h0);
      rd(A_ST, B_EN | B_RDY | B_DN, '1, "R5 ready before last flush");
      wr(A_DAT, 32'h0);
      rd(A_ST, B_EN | B_DN, '1, "R5 ready dropped after flush");

      // R9 user mode
      chk(user_mode, 1'b0, "R9 no user mode while mode set");
      wr(A_MD, 32'h0000_0002);
      @(negedge clk);
      chk(user_mode, 1'b0, "R9 no user mode while clock select set");
      wr(A_MD, 32'h0);
      @(negedge clk);
      chk(user_mode, 1'b1, "R9 user mode after exit");
      chk(clk_sel_pma, 1'b0, "R2 clk_sel_pma cleared");
      rd(A_ST, B_EN | B_DN | B_USR | B_FAB, '1, "R9 status user and fabric clock");

      // R10 read-only and unmapped
      wr(A_ST, 32'hFFFF_FFFF);
      wr(A_CAP, 32'h0);
      wr(A_EL, 32'hFFFF_FFFF);
      rd(A_ST, B_EN | B_DN | B_USR | B_FAB, '1, "R10 status write ignored");
      rd(A_CAP, 32'h0000_000B, '1, "R10 capability write ignored");
      rd(A_EL, 32'h0, '1, "R10 latch write ignored");
      rd(12'h300, 32'h0, '1, "R10 unmapped read");
      rd(A_DAT, 32'h0, '1, "R10 data offset reads zero");

      // R7 injected error
      err_inject = 1'b1;
      @(negedge clk);
      err_inject = 1'b0;
      repeat (4) @(negedge clk);
      chk(user_mode, 1'b0, "R7 error drops user mode");
      rd(A_ST, B_EN | B_DN | B_ERR, '1, "R7 status error");
      rd(A_EL, 32'h20, '1, "R7 latch set");
      wr(A_MD, 32'h2);
      wr(A_MD, 32'h3);
      wr(A_PG, 32'h1);
      repeat (D + 2) @(negedge clk);
      rd(A_ST, B_EN | B_RDY, '1, "R7 error and done cleared on new load");
      rd(A_EL, 32'h20, '1, "R7 latch survives new load");

      // R8 sequencing error
      do_reset();
      rd(A_EL, 32'h0, '1, "R7 latch cleared by reset");
      wr(A_MD, 32'h0);
      @(negedge clk);
      chk(user_mode, 1'b0, "R9 no user mode without a load");
      wr(A_MD, 32'h1);
      repeat (2) @(negedge clk);
      rd(A_EL, 32'h20, '1, "R8 mode before clock select latches");
      rd(A_ST, B_EN | B_ERR, '1, "R8 status error");
      rd(A_MD, 32'h1, '1, "R2 mode stored despite error");

      @(negedge clk);
      @(negedge clk);
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R11 reads lost act=%0d exp=0", sb_q.size());
      end
      finish_run();
   end

endmodule